// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt events for a network controller into one cause vector and gates that vector through a per-bit enable mask to produce per-vector interrupt requests. Sixteen queue-cause bits (each receive or transmit queue is steered onto one of them elsewhere), one timer cause and a set of miscellaneous causes are latched on hardware strobes. A derived summary bit reports that any miscellaneous cause is pending.

Software reaches the block through a small register port with a write strobe, a read strobe and a 3-bit word address. The mask is never written directly. Separate write-one-to-set and write-one-to-clear registers change it, so concurrent handlers need no read-modify-write. Causes can be cleared by a read, by write-one-to-clear, or automatically once the message for a vector has gone out. Software can also raise causes itself, and can optionally restart the throttle timer of the affected vectors so that the interrupt goes out at once.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq_req` and `thr_rst` are zero.
- R2: A hardware event sets its cause bit in the cycle after the strobe, whatever the mask holds. Queue event i maps to bit i, the timer to bit 16, miscellaneous event k to bit 17+k, and the summary bit is bit 21. These positions apply to every cause-layout register.
- R3: `irq_req[i]` is 1 exactly when cause bit i and mask bit i are both 1.
- R4: Writing address 2 sets the mask bits written as 1. Writing address 3 clears the mask bits written as 1. Bits written as 0 keep their value. Reading address 2 returns the mask.
- R5: The summary bit (bit 21) reads 1 whenever any miscellaneous cause is 1. Software cannot set it directly. Clearing it, by write-one-to-clear or by auto-clear, clears every miscellaneous cause.
- R6: Address 0 holds the cause vector. With config bit 0 at 0, a read returns the vector and then clears all of it. A write clears the bits written as 1.
- R7: With config bit 0 (address 5) at 1, a read of address 0 clears only the miscellaneous causes and the summary bit. Queue and timer causes remain.
- R8: Auto-clear enable register (address 4): when `msg_sent[i]` pulses and enable bit i is 1, cause bit i clears. Causes whose enable bit is 0 are kept.
- R9: Writing address 1 sets the cause bits written as 1. If config bit 1 is 1, `thr_rst` also carries the written bits for the one cycle after the write. Otherwise `thr_rst` stays 0.
- R10: If a hardware event and any clear (read, write-one-to-clear, auto-clear) hit the same cause bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on address 0) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational from the addressed register |
| ev_queue | input | NQ | Queue event strobes |
| ev_timer | input | 1 | Timer event strobe |
| ev_misc | input | NM | Miscellaneous event strobes |
| msg_sent | input | NQ+NM+2 | Per-vector message-sent pulses |
| irq_req | output | NQ+NM+2 | Per-vector interrupt request |
| thr_rst | output | NQ+NM+2 | Per-vector throttle-timer restart strobe |

## Verification
The hardest situations to reach are those where a hardware event lands in the same cycle as a clear. Two of them are a read that clears and a write-one-to-clear. The bench produces them with a single-cycle drive task that asserts the register strobe and the event strobe on the same falling edge. It then reads the cause register again to see which side won. The partial read-clear mode is reached by filling queue, timer and miscellaneous causes together and reading twice. The second read shows what the first one spared.

// File: rtl/icm_pkg.sv
package icm_pkg;
   typedef enum logic [2:0] {
      REG_CAUSE = 3'd0,
      REG_CSET  = 3'd1,
      REG_MSET  = 3'd2,
      REG_MCLR  = 3'd3,
      REG_ACLR  = 3'd4,
      REG_CFG   = 3'd5
   } icm_reg_e;

   localparam int CFG_OCD_BIT = 0;
   localparam int CFG_IMM_BIT = 1;
endpackage

// File: rtl/icm_cause_store.sv
module icm_cause_store #(
   parameter int CW      = 22,
   parameter int MISC_LO = 17,
   parameter int MISC_N  = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-2:0] hw_set,
   input  logic [CW-2:0] sw_set,
   input  logic [CW-2:0] clr,
   output logic [CW-1:0] cause
);
   localparam int SW = CW - 1;

   logic [SW-1:0] bit_q;

   for (genvar gi = 0; gi < SW; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q[gi] <= 1'b0;
         else        bit_q[gi] <= (bit_q[gi] & ~clr[gi]) | hw_set[gi] | sw_set[gi];
      end
   end

   assign cause = {|bit_q[MISC_LO +: MISC_N], bit_q};
endmodule

// File: rtl/icm_mask_store.sv
module icm_mask_store #(
   parameter int CW = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] set_bits,
   input  logic [CW-1:0] clr_bits,
   output logic [CW-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= (mask | set_bits) & ~clr_bits;
   end
endmodule

// File: rtl/icm_ctrl_regs.sv
module icm_ctrl_regs #(
   parameter int CW      = 22,
   parameter bit THR_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          aclr_wr,
   input  logic          cfg_wr,
   input  logic          cset_wr,
   input  logic [CW-1:0] wdata,
   input  logic [1:0]    cfg_in,
   output logic [CW-1:0] aclr_en,
   output logic          ocd,
   output logic          imm,
   output logic [CW-1:0] thr_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aclr_en <= '0;
         ocd     <= 1'b0;
         imm     <= 1'b0;
      end else begin
         if (aclr_wr) aclr_en <= wdata;
         if (cfg_wr) begin
            ocd <= cfg_in[icm_pkg::CFG_OCD_BIT];
            imm <= cfg_in[icm_pkg::CFG_IMM_BIT];
         end
      end
   end

   logic [CW-1:0] strobe_d;
   assign strobe_d = (cset_wr && imm) ? wdata : '0;

   if (THR_REG) begin : g_thr_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) thr_rst <= '0;
         else        thr_rst <= strobe_d;
      end
   end else begin : g_thr_comb
      assign thr_rst = strobe_d;
   end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl #(
   parameter int NQ      = 16,
   parameter int NM      = 4,
   parameter int DW      = 32,
   parameter bit THR_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [2:0]           reg_addr,
   input  logic [DW-1:0]        reg_wdata,
   output logic [DW-1:0]        reg_rdata,
   input  logic [NQ-1:0]        ev_queue,
   input  logic                 ev_timer,
   input  logic [NM-1:0]        ev_misc,
   input  logic [NQ+NM+1:0]     msg_sent,
   output logic [NQ+NM+1:0]     irq_req,
   output logic [NQ+NM+1:0]     thr_rst
);
   import icm_pkg::*;

   localparam int CW      = NQ + NM + 2;
   localparam int SW      = CW - 1;
   localparam int OTH     = CW - 1;
   localparam int MISC_LO = NQ + 1;
   localparam logic [SW-1:0] MISC_SEL = SW'(((64'd1 << NM) - 64'd1) << MISC_LO);

   if (NQ < 1 || NM < 1) begin : g_bad_counts
      $error("irq_cause_ctrl: NQ and NM must be at least 1");
   end
   if (CW > DW) begin : g_bad_width
      $error("irq_cause_ctrl: cause vector wider than data bus");
   end
   if (CW > 64) begin : g_bad_wide
      $error("irq_cause_ctrl: cause vector limited to 64 bits");
   end

   logic sel_cause, sel_cset, sel_mset, sel_mclr, sel_aclr, sel_cfg;
   assign sel_cause = reg_addr == REG_CAUSE;
   assign sel_cset  = reg_addr == REG_CSET;
   assign sel_mset  = reg_addr == REG_MSET;
   assign sel_mclr  = reg_addr == REG_MCLR;
   assign sel_aclr  = reg_addr == REG_ACLR;
   assign sel_cfg   = reg_addr == REG_CFG;

   logic [CW-1:0] cause_vec, mask_vec, aclr_en;
   logic          ocd_q, imm_q;
   logic [CW-1:0] wd;
   assign wd = reg_wdata[CW-1:0];

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // clear sources; a summary-bit clear expands to every miscellaneous bit
   logic [CW-1:0] w1c_raw, ac_raw;
   logic [SW-1:0] rd_clr, w1c_eff, ac_eff, clr_all;
   assign w1c_raw = (reg_wr && sel_cause) ? wd : '0;
   assign ac_raw  = msg_sent & aclr_en;
   assign rd_clr  = (reg_rd && sel_cause) ? (ocd_q ? MISC_SEL : '1) : '0;
   assign w1c_eff = w1c_raw[SW-1:0] | (w1c_raw[OTH] ? MISC_SEL : '0);
   assign ac_eff  = ac_raw[SW-1:0]  | (ac_raw[OTH]  ? MISC_SEL : '0);
   assign clr_all = rd_clr | w1c_eff | ac_eff;

   logic [SW-1:0] hw_set, sw_set;
   assign hw_set = {ev_misc, ev_timer, ev_queue};
   assign sw_set = (reg_wr && sel_cset) ? wd[SW-1:0] : '0;

   icm_cause_store #(.CW(CW), .MISC_LO(MISC_LO), .MISC_N(NM)) u_cause (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (hw_set),
      .sw_set (sw_set),
      .clr    (clr_all),
      .cause  (cause_vec)
   );

   icm_mask_store #(.CW(CW)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits ((reg_wr && sel_mset) ? wd : '0),
      .clr_bits ((reg_wr && sel_mclr) ? wd : '0),
      .mask     (mask_vec)
   );

   icm_ctrl_regs #(.CW(CW), .THR_REG(THR_REG)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .aclr_wr (reg_wr && sel_aclr),
      .cfg_wr  (reg_wr && sel_cfg),
      .cset_wr (reg_wr && sel_cset),
      .wdata   (wd),
      .cfg_in  (reg_wdata[1:0]),
      .aclr_en (aclr_en),
      .ocd     (ocd_q),
      .imm     (imm_q),
      .thr_rst (thr_rst)
   );

   assign irq_req = cause_vec & mask_vec;

   always_comb begin
      reg_rdata = '0;
      unique case (1'b1)
         sel_cause: reg_rdata[CW-1:0] = cause_vec;
         sel_mset:  reg_rdata[CW-1:0] = mask_vec;
         sel_aclr:  reg_rdata[CW-1:0] = aclr_en;
         sel_cfg:   reg_rdata[1:0]    = {imm_q, ocd_q};
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk #(
   parameter int NQ = 16,
   parameter int NM = 4,
   parameter int CW = 22
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [2:0]    reg_addr,
   input logic [CW-1:0] wd,
   input logic [NQ-1:0] ev_queue,
   input logic [NM-1:0] ev_misc,
   input logic [CW-1:0] msg_sent,
   input logic [CW-1:0] irq_req,
   input logic [CW-1:0] thr_rst,
   input logic [CW-1:0] cause_vec,
   input logic          ocd_q,
   input logic          imm_q
);
   import icm_pkg::*;

   AST_MASKCLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == REG_MCLR) |=> ((irq_req & $past(wd)) == '0)); // R4

   AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_queue) |=> ((cause_vec[NQ-1:0] & $past(ev_queue)) == $past(ev_queue))); // R10

   AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_misc) |=> cause_vec[CW-1]); // R5

   AST_THR_NEEDS_IMM: assert property (@(posedge clk) disable iff (!rst_n)
      (|thr_rst) |-> $past(reg_wr && reg_addr == REG_CSET && imm_q)); // R9

   AST_OCD_SPARES_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && reg_addr == REG_CAUSE && ocd_q && msg_sent == '0)
      |=> ((cause_vec[NQ-1:0] & $past(cause_vec[NQ-1:0])) == $past(cause_vec[NQ-1:0]))); // R7
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.NQ(NQ), .NM(NM), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .wd        (reg_wdata[CW-1:0]),
   .ev_queue  (ev_queue),
   .ev_misc   (ev_misc),
   .msg_sent  (msg_sent),
   .irq_req   (irq_req),
   .thr_rst   (thr_rst),
   .cause_vec (cause_vec),
   .ocd_q     (ocd_q),
   .imm_q     (imm_q)
);

// File: tb/test_irq_cause_ctrl.sv
`timescale 1ns/1ps
module test_irq_cause_ctrl;
   localparam int NQ = 16;
   localparam int NM = 4;
   localparam int DW = 32;
   localparam int CW = NQ + NM + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NQ-1:0] ev_queue = '0;
   logic          ev_timer = 1'b0;
   logic [NM-1:0] ev_misc = '0;
   logic [CW-1:0] msg_sent = '0;
   logic [CW-1:0] irq_req, thr_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_cause_ctrl #(.NQ(NQ), .NM(NM), .DW(DW)) i_irq_cause_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_queue(ev_queue), .ev_timer(ev_timer), .ev_misc(ev_misc),
      .msg_sent(msg_sent), .irq_req(irq_req), .thr_rst(thr_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: drive on a falling edge, sample read data, release on the next
   task automatic cyc(input logic wr, input logic rd, input logic [2:0] a,
                      input logic [31:0] d, input logic [NQ-1:0] q, input logic t,
                      input logic [NM-1:0] m, input logic [CW-1:0] ms,
                      output logic [31:0] rdv);
      @(negedge clk);
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
      ev_queue = q; ev_timer = t; ev_misc = m; msg_sent = ms;
      #1 rdv = reg_rdata;
      @(negedge clk);
      reg_wr = 0; reg_rd = 0; reg_wdata = '0;
      ev_queue = '0; ev_timer = 0; ev_misc = '0; msg_sent = '0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      logic [31:0] x;
      cyc(1, 0, a, d, '0, 0, '0, '0, x);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      cyc(0, 1, a, '0, '0, 0, '0, '0, v);
   endtask

   task automatic ev(input logic [NQ-1:0] q, input logic t, input logic [NM-1:0] m);
      logic [31:0] x;
      cyc(0, 0, 3'd0, '0, q, t, m, '0, x);
   endtask

   typedef struct packed {
      logic        is_clr;
      logic [31:0] data;
      logic [31:0] exp;
   } mvec_t;

   localparam mvec_t MTAB [7] = '{
      '{1'b0, 32'h0000_00F0, 32'h0000_00F0},
      '{1'b0, 32'h0000_0003, 32'h0000_00F3},
      '{1'b1, 32'h0000_0030, 32'h0000_00C3},
      '{1'b0, 32'h0000_0000, 32'h0000_00C3},
      '{1'b1, 32'h0000_0000, 32'h0000_00C3},
      '{1'b0, 32'h003F_0000, 32'h003F_00C3},
      '{1'b1, 32'h003F_FFFF, 32'h0000_0000}
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_req", 32'(irq_req), 0);
      chk("R1 thr_rst", 32'(thr_rst), 0);
      rd(3'd0, v); chk("R1 cause", v, 0);
      rd(3'd2, v); chk("R1 mask", v, 0);
      rd(3'd4, v); chk("R1 aclr", v, 0);
      rd(3'd5, v); chk("R1 cfg", v, 0);

      // R4 mask set/clear table
      foreach (MTAB[i]) begin
         wr(MTAB[i].is_clr ? 3'd3 : 3'd2, MTAB[i].data);
         rd(3'd2, v);
         chk("R4 mask table", v, MTAB[i].exp);
      end

      // R2 / R3: latch while masked, request once unmasked
      ev(16'h0020, 1'b1, '0);
      chk("R3 masked no req", 32'(irq_req), 0);
      wr(3'd2, 32'h0000_0020);
      chk("R3 req unmasked", 32'(irq_req), 32'h0000_0020);
      rd(3'd0, v); chk("R2 cause latched", v, 32'h0001_0020);
      rd(3'd0, v); chk("R6 read cleared", v, 0);
      chk("R3 req gone", 32'(irq_req), 0);
      wr(3'd3, 32'h0000_0020);

      // R6 write-one-to-clear
      ev(16'h0003, 1'b0, '0);
      wr(3'd0, 32'h0000_0001);
      rd(3'd0, v); chk("R6 w1c", v, 32'h0000_0002);

      // R5 summary bit
      ev('0, 1'b0, 4'b0100);
      rd(3'd0, v); chk("R5 summary", v, (32'd1 << 19) | (32'd1 << 21));
      wr(3'd1, 32'd1 << 21);
      rd(3'd0, v); chk("R5 no sw set", v, 0);
      ev('0, 1'b0, 4'b0001);
      wr(3'd0, 32'd1 << 21);
      rd(3'd0, v); chk("R5 w1c summary", v, 0);

      // R7 partial read-clear
      wr(3'd5, 32'h1);
      ev(16'h0002, 1'b1, 4'b0001);
      rd(3'd0, v); chk("R7 first read", v, 32'h0023_0002);
      rd(3'd0, v); chk("R7 survivors", v, 32'h0001_0002);
      wr(3'd0, 32'h0001_0002);
      rd(3'd0, v); chk("R7 w1c", v, 0);
      wr(3'd5, 32'h0);

      // R8 auto-clear on message sent
      wr(3'd4, 32'h1);
      wr(3'd2, 32'h3);
      ev(16'h0003, 1'b0, '0);
      chk("R8 both req", 32'(irq_req), 32'h3);
      cyc(0, 0, 3'd0, '0, '0, 0, '0, CW'(3), v);
      chk("R8 auto-clear", 32'(irq_req), 32'h2);
      rd(3'd0, v);
      wr(3'd3, 32'h3);
      wr(3'd4, 32'h0);

      // R9 software cause set and throttle restart
      wr(3'd1, 32'h4);
      chk("R9 no strobe", 32'(thr_rst), 0);
      rd(3'd0, v); chk("R9 sw set", v, 32'h4);
      wr(3'd5, 32'h2);
      wr(3'd1, 32'h8);
      chk("R9 strobe", 32'(thr_rst), 32'h8);
      ev('0, 1'b0, '0);
      chk("R9 strobe ends", 32'(thr_rst), 0);
      rd(3'd0, v); chk("R9 sw set imm", v, 32'h8);
      wr(3'd5, 32'h0);

      // R10 event beats a clear in the same cycle
      cyc(0, 1, 3'd0, '0, 16'h0080, 0, '0, '0, v);
      rd(3'd0, v); chk("R10 vs read", v, 32'h0000_0080);
      cyc(1, 0, 3'd0, 32'h0000_0100, 16'h0100, 0, '0, '0, v);
      rd(3'd0, v); chk("R10 vs w1c", v, 32'h0000_0100);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule